// File: doc/BRIEF.md
# Register-Mapped Countdown Timer with Interrupt

This peripheral has one down-counter and a small interrupt unit, both reached through a single-cycle register bus. Software first stores a limit. It then writes command words to a control register: one command copies the limit into the counter, one halts counting, and one starts or resumes it. The same control word also picks which of four tick-enable inputs drives the counter. Those inputs are single-cycle pulses on the system clock.

Limits larger than 2048 are scaled automatically. The counter is loaded with the limit shifted right by eleven bits, and it then steps once per 2048 selected pulses. The counter expires when a tick arrives while its value is one or less. It then reloads and keeps running, and it latches a raw pending bit. That bit is gated by a mask register to form the interrupt output. Software clears it by writing ones to an acknowledge offset.

The bus is active in any cycle where `bus_sel` is high. Writes take effect at that clock edge. Read data is combinational, and it is zero when no read is in progress.

Top module: `mmio_countdown_timer`

## Requirements
- R1: After reset, every readable offset returns zero and `irq_o` is low.
- R2: A control write (offset 0x08) with bits [1:0] = 0 copies the scaled limit (held at offset 0x00) into the count, which reads back at offset 0x04.
- R3: Control command 1 halts the count and command 2 starts or resumes it. While running, each effective tick lowers the count by one.
- R4: Control bits [4:2] equal to 4, 5, 6 or 7 select `src_tick[0]`, `[1]`, `[2]` or `[3]` respectively. Pulses on the other inputs are ignored.
- R5: With bits [4:2] at 0 through 3, the count never advances.
- R6: A tick arriving while the count is 1 or 0 is an expiry, and it sets bit 0 of the raw status at offset 0x50.
- R7: On expiry the counter reloads the scaled limit and keeps running.
- R8: Offset 0x48 is the read-write mask. Offset 0x54 returns raw AND mask. `irq_o` is high exactly while raw bit 0 and mask bit 0 are both set.
- R9: A write to offset 0x4C clears each raw bit written as 1 and leaves bits written as 0 unchanged.
- R10: If an expiry and an acknowledge of bit 0 land in the same cycle, the bit stays set.
- R11: A limit above 2048 loads the counter with limit >> 11, and the counter then steps once per 2048 selected pulses. A limit of 2048 or less is used unscaled.
- R12: Unmapped offsets read as zero. Writes to unmapped offsets or to the read-only offsets 0x04, 0x50 and 0x54 change nothing.
- R13: A control write with bits [1:0] = 3 is ignored as a whole, and the control register keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (7) | Byte offset |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, zero when idle |
| src_tick | input | 4 | Rate enable pulses, one per source |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The assertions assume three things about the inputs. Each tick input is a clean single-cycle pulse on the system clock. The bus never presents a write and a read in the same cycle. Reset is held long enough for the internal synchronizer to settle. The bench drives all inputs from one sequential thread on falling edges, raises at most one tick per cycle except where a collision is under test, and keeps every access to one cycle. Because of this, each count value it expects follows from a plain tally of the pulses it has issued.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int OFF_LIMIT  = 'h00;
  localparam int OFF_COUNT  = 'h04;
  localparam int OFF_CTRL   = 'h08;
  localparam int OFF_MASK   = 'h48;
  localparam int OFF_ACK    = 'h4C;
  localparam int OFF_RAW    = 'h50;
  localparam int OFF_MASKED = 'h54;

  typedef enum logic [1:0] {
    CMD_LOAD = 2'd0,
    CMD_STOP = 2'd1,
    CMD_RUN  = 2'd2,
    CMD_BAD  = 2'd3
  } cmd_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs import tmr_pkg::*; #(
  parameter int DW    = 32,
  parameter int AW    = 7,
  parameter int SEL_W = 3,
  parameter int NIRQ  = 1,
  localparam int CTRL_W = SEL_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     count_i,
  input  logic [NIRQ-1:0]   raw_i,
  output logic [DW-1:0]     limit_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              run_q,
  output logic [NIRQ-1:0]   mask_q,
  output logic              load_o,
  output logic [NIRQ-1:0]   ack_o
);
  localparam logic [AW-1:0] A_LIMIT  = AW'(OFF_LIMIT);
  localparam logic [AW-1:0] A_COUNT  = AW'(OFF_COUNT);
  localparam logic [AW-1:0] A_CTRL   = AW'(OFF_CTRL);
  localparam logic [AW-1:0] A_MASK   = AW'(OFF_MASK);
  localparam logic [AW-1:0] A_ACK    = AW'(OFF_ACK);
  localparam logic [AW-1:0] A_RAW    = AW'(OFF_RAW);
  localparam logic [AW-1:0] A_MASKED = AW'(OFF_MASKED);

  logic              wr_en;
  logic              limit_we, ctrl_we, mask_we;
  logic              run_d;

  assign wr_en = sel && wr;

  always_comb begin
    limit_we = 1'b0;
    ctrl_we  = 1'b0;
    mask_we  = 1'b0;
    run_d    = run_q;
    load_o   = 1'b0;
    ack_o    = '0;
    if (wr_en) begin
      case (addr)
        A_LIMIT: limit_we = 1'b1;
        A_CTRL: begin
          if (wdata[1:0] != CMD_BAD) begin
            ctrl_we = 1'b1;
            case (wdata[1:0])
              CMD_LOAD: load_o = 1'b1;
              CMD_STOP: run_d  = 1'b0;
              CMD_RUN:  run_d  = 1'b1;
              default:  run_d  = run_q;
            endcase
          end
        end
        A_MASK:  mask_we = 1'b1;
        A_ACK:   ack_o   = wdata[NIRQ-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (sel && !wr) begin
      case (addr)
        A_LIMIT:  rdata = limit_q;
        A_COUNT:  rdata = count_i;
        A_CTRL:   rdata = DW'(ctrl_q);
        A_MASK:   rdata = DW'(mask_q);
        A_RAW:    rdata = DW'(raw_i);
        A_MASKED: rdata = DW'(raw_i & mask_q);
        default:  rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
      ctrl_q  <= '0;
      run_q   <= 1'b0;
      mask_q  <= '0;
    end else begin
      if (limit_we) limit_q <= wdata;
      if (ctrl_we)  ctrl_q  <= wdata[CTRL_W-1:0];
      if (ctrl_we)  run_q   <= run_d;
      if (mask_we)  mask_q  <= wdata[NIRQ-1:0];
    end
  end
endmodule

// File: rtl/tmr_tick.sv
module tmr_tick #(
  parameter int SEL_W = 3,
  parameter int PSC_W = 11,
  localparam int NSRC = 1 << (SEL_W - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [NSRC-1:0]  src_tick,
  input  logic             run,
  input  logic             prescale,
  input  logic             clr,
  output logic             tick
);
  logic             sel_pulse;
  logic             step;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic             psc_en;

  // upper half of the select code space maps onto the tick inputs
  assign sel_pulse = src_sel[SEL_W-1] && src_tick[src_sel[SEL_W-2:0]];
  assign step      = run && sel_pulse;

  always_comb begin
    psc_en = 1'b0;
    psc_d  = psc_q;
    if (clr) begin
      psc_en = 1'b1;
      psc_d  = '0;
    end else if (step && prescale) begin
      psc_en = 1'b1;
      psc_d  = psc_q + 1'b1;
    end
  end

  assign tick = step && !clr && (!prescale || (psc_q == '1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      psc_q <= '0;
    else if (psc_en) psc_q <= psc_d;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] reload_val,
  input  logic          tick,
  output logic [DW-1:0] count_q,
  output logic          expire
);
  logic [DW-1:0] count_d;
  logic          count_en;

  assign expire = tick && !load && (count_q <= DW'(1));

  always_comb begin
    count_en = load || tick;
    if (load || expire) count_d = reload_val;
    else                count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int NIRQ = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] set_i,
  input  logic [NIRQ-1:0] ack_i,
  input  logic [NIRQ-1:0] mask_i,
  output logic [NIRQ-1:0] raw_q,
  output logic            irq_o
);
  logic [NIRQ-1:0] raw_d;
  logic            raw_en;

  // set has priority over a same-cycle acknowledge
  assign raw_d  = (raw_q & ~ack_i) | set_i;
  assign raw_en = |(set_i | ack_i);
  assign irq_o  = |(raw_q & mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= '0;
    else if (raw_en) raw_q <= raw_d;
  end
endmodule

// File: rtl/mmio_countdown_timer.sv
module mmio_countdown_timer #(
  parameter int DW    = 32,
  parameter int AW    = 7,
  parameter int SEL_W = 3,
  parameter int PSC_W = 11,
  parameter int NIRQ  = 1,
  localparam int NSRC = 1 << (SEL_W - 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] src_tick,
  output logic            irq_o
);
  localparam int CTRL_W = SEL_W + 2;
  localparam logic [DW-1:0] PSC_DIV = DW'(1) << PSC_W;

  logic              rst_meta_n, rst_sync_n;
  logic [DW-1:0]     limit_q, count_q, reload_val;
  logic [CTRL_W-1:0] ctrl_q;
  logic              run_q, load, tick, expire, prescale;
  logic [NIRQ-1:0]   mask_q, ack, raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign prescale   = limit_q > PSC_DIV;
  assign reload_val = prescale ? (limit_q >> PSC_W) : limit_q;

  tmr_regs #(.DW(DW), .AW(AW), .SEL_W(SEL_W), .NIRQ(NIRQ)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .sel(bus_sel), .wr(bus_wr),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .count_i(count_q), .raw_i(raw_q), .limit_q(limit_q), .ctrl_q(ctrl_q),
    .run_q(run_q), .mask_q(mask_q), .load_o(load), .ack_o(ack)
  );

  tmr_tick #(.SEL_W(SEL_W), .PSC_W(PSC_W)) u_tick (
    .clk(clk), .rst_n(rst_sync_n), .src_sel(ctrl_q[CTRL_W-1:2]),
    .src_tick(src_tick), .run(run_q), .prescale(prescale), .clr(load),
    .tick(tick)
  );

  tmr_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .load(load), .reload_val(reload_val),
    .tick(tick), .count_q(count_q), .expire(expire)
  );

  tmr_irq #(.NIRQ(NIRQ)) u_irq (
    .clk(clk), .rst_n(rst_sync_n), .set_i(NIRQ'(expire)), .ack_i(ack),
    .mask_i(mask_q), .raw_q(raw_q), .irq_o(irq_o)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker import tmr_pkg::*; #(
  parameter int DW    = 32,
  parameter int AW    = 7,
  parameter int SEL_W = 3,
  parameter int PSC_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [1:0]       wr_cmd,
  input logic             wr_bit0,
  input logic [DW-1:0]    limit_q,
  input logic [SEL_W-1:0] src_sel,
  input logic             run_q,
  input logic [DW-1:0]    count_q,
  input logic             expire,
  input logic             raw0,
  input logic             mask0,
  input logic             irq_o
);
  localparam logic [DW-1:0] PSC_DIV = DW'(1) << PSC_W;

  logic ctrl_wr, load_wr, ack0_wr;
  assign ctrl_wr = bus_sel && bus_wr && (bus_addr == AW'(OFF_CTRL));
  assign load_wr = ctrl_wr && (wr_cmd == 2'd0);
  assign ack0_wr = bus_sel && bus_wr && (bus_addr == AW'(OFF_ACK)) && wr_bit0;

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> count_q == (($past(limit_q) > PSC_DIV) ? ($past(limit_q) >> PSC_W) : $past(limit_q)));

  // R3
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !load_wr) |=> $stable(count_q));

  // R5
  idle_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_sel[SEL_W-1] && !load_wr) |=> $stable(count_q));

  // R6
  expire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> raw0);

  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack0_wr && !expire) |=> !raw0);

  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && mask0 && !(bus_sel && bus_wr)) |=> irq_o);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (raw0 && mask0));

  // R10
  expire_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ack0_wr) |=> raw0);
endmodule

bind mmio_countdown_timer tmr_checker #(.DW(DW), .AW(AW), .SEL_W(SEL_W), .PSC_W(PSC_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .wr_cmd(bus_wdata[1:0]), .wr_bit0(bus_wdata[0]),
  .limit_q(limit_q), .src_sel(ctrl_q[SEL_W+1:2]), .run_q(run_q),
  .count_q(count_q), .expire(expire), .raw0(raw_q[0]), .mask0(mask_q[0]),
  .irq_o(irq_o)
);

// File: tb/mmio_countdown_timer_tb.sv
module mmio_countdown_timer_tb;
  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  src_tick;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [6:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t exp_q[$];

  mmio_countdown_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_tick(src_tick), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // monitor: compares each read one time unit before the next rising edge
  always begin
    @(negedge clk);
    #1;
    if (bus_sel && !bus_wr) begin
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: read with nothing expected");
      end else begin
        item_t it;
        it = exp_q.pop_front();
        checks++;
        if (bus_rdata !== it.exp || bus_addr !== it.addr) begin
          fails++;
          $display("FAIL %s: addr %h actual %h expected %h", it.tag, bus_addr, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic expect_read(input logic [6:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.addr = a; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pulse(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      src_tick[idx] = 1'b1;
      @(negedge clk);
      src_tick[idx] = 1'b0;
    end
  endtask

  task automatic check_irq(input logic e, input string tag);
    checks++;
    if (irq_o !== e) begin
      fails++;
      $display("FAIL %s: irq_o actual %b expected %b", tag, irq_o, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; src_tick = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    expect_read(7'h00, 0, "R1 limit");
    expect_read(7'h04, 0, "R1 count");
    expect_read(7'h08, 0, "R1 ctrl");
    expect_read(7'h48, 0, "R1 mask");
    expect_read(7'h50, 0, "R1 raw");
    expect_read(7'h54, 0, "R1 masked");
    check_irq(1'b0, "R1 irq");

    // R2 load with source 4
    bus_write(7'h00, 5);
    expect_read(7'h00, 5, "R2 limit readback");
    bus_write(7'h08, 32'h10);
    expect_read(7'h04, 5, "R2 load");
    pulse(0, 2);
    expect_read(7'h04, 5, "R3 not yet running");
    // R3 run, R4 source choice
    bus_write(7'h08, 32'h12);
    pulse(0, 2);
    expect_read(7'h04, 3, "R3 decrement");
    pulse(1, 1); pulse(2, 1); pulse(3, 1);
    expect_read(7'h04, 3, "R4 other sources ignored");
    bus_write(7'h08, 32'h11);
    pulse(0, 1);
    expect_read(7'h04, 3, "R3 stop");

    // R13 illegal command ignored
    bus_write(7'h08, 32'h13);
    expect_read(7'h08, 32'h11, "R13 ctrl kept");
    pulse(0, 1);
    expect_read(7'h04, 3, "R13 still halted");

    // R5 disabled source code 1
    bus_write(7'h08, 32'h06);
    expect_read(7'h08, 32'h06, "R5 ctrl");
    for (int s = 0; s < 4; s++) pulse(s, 1);
    expect_read(7'h04, 3, "R5 no advance");

    // R6 / R7 expiry and periodic reload
    bus_write(7'h08, 32'h12);
    pulse(0, 2);
    expect_read(7'h04, 1, "R6 before expiry");
    expect_read(7'h50, 0, "R6 not yet pending");
    pulse(0, 1);
    expect_read(7'h50, 1, "R6 raw set");
    expect_read(7'h04, 5, "R7 reload");
    expect_read(7'h54, 0, "R8 masked off");
    check_irq(1'b0, "R8 irq masked");
    pulse(0, 1);
    expect_read(7'h04, 4, "R7 keeps running");

    // R8 mask
    bus_write(7'h48, 1);
    check_irq(1'b1, "R8 irq raised");
    expect_read(7'h48, 1, "R8 mask readback");
    expect_read(7'h54, 1, "R8 masked status");

    // R9 acknowledge
    bus_write(7'h4C, 32'hFFFF_FFFE);
    expect_read(7'h50, 1, "R9 zero bit keeps");
    check_irq(1'b1, "R9 irq held");
    bus_write(7'h4C, 1);
    expect_read(7'h50, 0, "R9 cleared");
    check_irq(1'b0, "R9 irq dropped");

    // R10 expiry and ack in the same cycle
    pulse(0, 3);
    expect_read(7'h04, 1, "R10 setup");
    @(negedge clk);
    src_tick[0] = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 7'h4C; bus_wdata = 1;
    @(negedge clk);
    src_tick[0] = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    expect_read(7'h50, 1, "R10 expiry wins");
    check_irq(1'b1, "R10 irq");
    expect_read(7'h04, 5, "R10 reload");

    // R11 prescaled limit
    bus_write(7'h4C, 1);
    bus_write(7'h08, 32'h11);
    bus_write(7'h00, 4100);
    bus_write(7'h08, 32'h1C);
    expect_read(7'h04, 2, "R11 scaled load");
    bus_write(7'h08, 32'h1E);
    pulse(3, 2047);
    expect_read(7'h04, 2, "R11 before wrap");
    pulse(3, 1);
    expect_read(7'h04, 1, "R11 one step per 2048");
    // R11 boundary: exactly 2048 is unscaled
    bus_write(7'h08, 32'h1D);
    bus_write(7'h00, 2048);
    bus_write(7'h08, 32'h1C);
    expect_read(7'h04, 2048, "R11 boundary load");
    bus_write(7'h08, 32'h1E);
    pulse(3, 1);
    expect_read(7'h04, 2047, "R11 boundary unscaled");

    // R12 unmapped and read-only
    expect_read(7'h20, 0, "R12 unmapped read");
    bus_write(7'h04, 32'h0000_FFFF);
    expect_read(7'h04, 2047, "R12 count read-only");
    bus_write(7'h50, 1);
    expect_read(7'h50, 0, "R12 raw read-only");
    bus_write(7'h30, 32'hFFFF_FFFF);
    expect_read(7'h00, 2048, "R12 unmapped write");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d reads never seen", exp_q.size());
    end
    finish_run();
  end
endmodule